// File: doc/BRIEF.md
# Input Gamma Lookup Table

This block maps each 8-bit colour channel of an incoming pixel to a 12-bit unsigned fraction (u0.12). It does this with a direct-index table of 256 entries per channel. Two complete copies of the table, RAM A and RAM B, are kept. Software rewrites the copy that is idle while the other one serves pixels, then switches the lookup mode so the new curve takes effect at once. Pixel inputs wider than 8 bits keep only their top 8 bits for the lookup.

The host loads a table through a small sequential port. Writing the index register sets the starting entry and resets a three-state write sequencer to the red channel. Each data write then goes to the current channel, and the sequencer walks red, green, blue. After the blue word it moves back to red and the index increments, wrapping from 255 to 0. The write-enable mask has bit 0 for red, bit 1 for green and bit 2 for blue. A channel whose mask bit is clear keeps its entry, but the sequencer still advances. The sequencer states are SEQ_RED, SEQ_GRN and SEQ_BLU. The transitions are:
- load: any state goes to SEQ_RED on an index write.
- step: SEQ_RED goes to SEQ_GRN, and SEQ_GRN goes to SEQ_BLU, on a data write.
- wrap: SEQ_BLU goes to SEQ_RED on a data write, and the index increments.

A registered status field reports which RAM is in use, combined with a companion curve selection.

Top module: `in_gamma_lut`

## Requirements
- R1: While reset is asserted, out_valid and status are 0. After reset the write index is 0 and the sequencer expects a red word.
- R2: An index write loads the index from idx_val. The next data word goes to the red channel of that entry, even when the index write arrives in the middle of a triplet.
- R3: Data words are written in the order red, green, blue at the current index. After blue the index increments by one and wraps from 255 to 0.
- R4: we_mask bit 0 enables red, bit 1 green and bit 2 blue. A word whose channel bit is clear leaves that entry unchanged, and the sequencer still advances.
- R5: ram_sel 0 writes RAM A and ram_sel 1 writes RAM B. The other RAM is left untouched.
- R6: With lut_mode 2 the output is the RAM A entry addressed by the pixel channel, and with lut_mode 3 it is the RAM B entry. Results and out_valid appear one clock after in_valid, and a lookup sees a word written in the same clock only on later pixels.
- R7: With lut_mode 0 or 1 (bypass) each output is the 8-bit channel value followed by four zero bits.
- R8: With IN_W wider than 8, only the top 8 bits of each pixel channel are used, in both lookup and bypass.
- R9: status is registered one clock after lut_mode and curve_sel. Bypass gives 0. RAM A gives 1, 3 or 4 for curve_sel 0, 1 or 2, and RAM B gives 2, 5 or 6. curve_sel 3 is treated as 0.
- R10: When an index write and a data write arrive in the same clock, the index write wins and the data word is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idx_wr | input | 1 | Load the write index |
| idx_val | input | 8 | Index value to load |
| data_wr | input | 1 | Write one data word at the current index and channel |
| data_val | input | 12 | u0.12 entry value |
| we_mask | input | 3 | Channel write enables: bit 0 red, bit 1 green, bit 2 blue |
| ram_sel | input | 1 | Target RAM for writes: 0 selects A, 1 selects B |
| lut_mode | input | 2 | 0 or 1 bypass, 2 RAM A, 3 RAM B |
| curve_sel | input | 2 | Companion curve selection reported in status |
| in_valid | input | 1 | Pixel valid |
| in_r | input | IN_W | Red channel in |
| in_g | input | IN_W | Green channel in |
| in_b | input | IN_W | Blue channel in |
| out_valid | output | 1 | Pixel valid, delayed by one clock |
| out_r | output | 12 | Red result |
| out_g | output | 12 | Green result |
| out_b | output | 12 | Blue result |
| status | output | 3 | Active RAM and curve code |

## Verification
The bench chases these corner cases:
- Index wrap from 255 to 0 after a full load. An off-by-one there would overwrite the wrong entry, and the lookup of entry 0 would then disagree with the model.
- A masked-off channel inside a triplet. A sequencer that stalled on it, instead of advancing, would shift the following words into the wrong channels.
- An index write that arrives mid-triplet, or together with a data word. A design that kept the old phase or let the word through would corrupt an entry.
- Writes to one RAM while the other is looked up, and bypass with non-zero low input bits. These expose a bad RAM select or bad truncation.

// File: rtl/in_gamma_pkg.sv
package in_gamma_pkg;
    typedef enum logic [1:0] {
        SEQ_RED = 2'd0,
        SEQ_GRN = 2'd1,
        SEQ_BLU = 2'd2
    } seq_state_t;

    localparam logic [1:0] MODE_RAM_A = 2'd2;
    localparam logic [1:0] MODE_RAM_B = 2'd3;
    localparam int         NUM_CH     = 3;
    localparam int         NUM_RAM    = 2;

    function automatic logic [2:0] status_code(input logic [1:0] mode,
                                               input logic [1:0] curve);
        logic [2:0] code;
        code = 3'd0;
        if (mode == MODE_RAM_A) begin
            unique case (curve)
                2'd1:    code = 3'd3;
                2'd2:    code = 3'd4;
                default: code = 3'd1;
            endcase
        end else if (mode == MODE_RAM_B) begin
            unique case (curve)
                2'd1:    code = 3'd5;
                2'd2:    code = 3'd6;
                default: code = 3'd2;
            endcase
        end
        return code;
    endfunction
endpackage

// File: rtl/in_gamma_wr_seq.sv
module in_gamma_wr_seq
    import in_gamma_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_val,
    input  logic             data_wr,
    input  logic [2:0]       we_mask,
    output logic [2:0]       wr_en,
    output logic [IDX_W-1:0] wr_addr
);
    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             word_go;

    assign word_go = data_wr && !idx_wr;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        if (idx_wr) begin
            state_d = SEQ_RED;
            idx_d   = idx_val;
        end else if (data_wr) begin
            unique case (state_q)
                SEQ_RED: state_d = SEQ_GRN;
                SEQ_GRN: state_d = SEQ_BLU;
                SEQ_BLU: begin
                    state_d = SEQ_RED;
                    idx_d   = idx_q + 1'b1;
                end
                default: state_d = SEQ_RED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_RED;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_comb begin
        wr_en = 3'b000;
        unique case (state_q)
            SEQ_RED: wr_en[0] = word_go && we_mask[0];
            SEQ_GRN: wr_en[1] = word_go && we_mask[1];
            SEQ_BLU: wr_en[2] = word_go && we_mask[2];
            default: wr_en    = 3'b000;
        endcase
    end

    assign wr_addr = idx_q;

    // R3
    blu_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_go && state_q == SEQ_BLU) |=>
            (state_q == SEQ_RED && idx_q == IDX_W'($past(idx_q) + 1'b1)));

    // R2
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> (state_q == SEQ_RED && idx_q == $past(idx_val)));

    // R10
    idx_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_wr && data_wr) |-> (wr_en == 3'b000));
endmodule

// File: rtl/in_gamma_bank.sv
module in_gamma_bank #(
    parameter int IDX_W = 8,
    parameter int ENT_W = 12
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [ENT_W-1:0] wdata,
    input  logic [IDX_W-1:0] raddr,
    output logic [ENT_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [ENT_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/in_gamma_lut.sv
module in_gamma_lut
    import in_gamma_pkg::*;
#(
    parameter int IN_W  = 10,
    parameter int IDX_W = 8,
    parameter int ENT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_wr,
    input  logic [IDX_W-1:0] idx_val,
    input  logic             data_wr,
    input  logic [ENT_W-1:0] data_val,
    input  logic [2:0]       we_mask,
    input  logic             ram_sel,
    input  logic [1:0]       lut_mode,
    input  logic [1:0]       curve_sel,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_r,
    input  logic [IN_W-1:0]  in_g,
    input  logic [IN_W-1:0]  in_b,
    output logic             out_valid,
    output logic [ENT_W-1:0] out_r,
    output logic [ENT_W-1:0] out_g,
    output logic [ENT_W-1:0] out_b,
    output logic [2:0]       status
);
    localparam int PAD_W = ENT_W - IDX_W;

    logic [2:0]       ch_we;
    logic [IDX_W-1:0] waddr;
    logic [IDX_W-1:0] pix_idx [NUM_CH];
    logic [ENT_W-1:0] rd_data [NUM_RAM][NUM_CH];
    logic [ENT_W-1:0] byp_q   [NUM_CH];
    logic [ENT_W-1:0] res     [NUM_CH];
    logic             valid_q, use_lut_q, use_b_q;
    logic [2:0]       status_q;

    assign pix_idx[0] = in_r[IN_W-1 -: IDX_W];
    assign pix_idx[1] = in_g[IN_W-1 -: IDX_W];
    assign pix_idx[2] = in_b[IN_W-1 -: IDX_W];

    in_gamma_wr_seq #(.IDX_W(IDX_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .idx_val(idx_val),
        .data_wr(data_wr),
        .we_mask(we_mask),
        .wr_en  (ch_we),
        .wr_addr(waddr)
    );

    for (genvar r = 0; r < NUM_RAM; r++) begin : g_ram
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            in_gamma_bank #(.IDX_W(IDX_W), .ENT_W(ENT_W)) u_bank (
                .clk  (clk),
                .we   (ch_we[c] && (ram_sel == r[0])),
                .waddr(waddr),
                .wdata(data_val),
                .raddr(pix_idx[c]),
                .rdata(rd_data[r][c])
            );
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q   <= 1'b0;
            use_lut_q <= 1'b0;
            use_b_q   <= 1'b0;
            status_q  <= 3'd0;
        end else begin
            valid_q   <= in_valid;
            use_lut_q <= lut_mode[1];
            use_b_q   <= lut_mode[0];
            status_q  <= status_code(lut_mode, curve_sel);
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_out
        always_ff @(posedge clk) byp_q[c] <= {pix_idx[c], {PAD_W{1'b0}}};
        assign res[c] = !use_lut_q ? byp_q[c] :
                        (use_b_q ? rd_data[1][c] : rd_data[0][c]);
    end

    assign out_valid = valid_q;
    assign out_r     = res[0];
    assign out_g     = res[1];
    assign out_b     = res[2];
    assign status    = status_q;

    // R6
    valid_pipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid)));

    // R7
    bypass_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && out_valid && !$past(lut_mode[1])) |->
            (out_r[PAD_W-1:0] == '0 && out_g[PAD_W-1:0] == '0 && out_b[PAD_W-1:0] == '0));

    // R9
    status_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(lut_mode) == MODE_RAM_A) |->
            (status == 3'd1 || status == 3'd3 || status == 3'd4));

    // R9
    status_byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(lut_mode[1])) |-> (status == 3'd0));
endmodule

// File: tb/in_gamma_lut_tb.sv
module in_gamma_lut_tb;
    localparam int IN_W = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            idx_wr = 1'b0;
    logic [7:0]      idx_val = '0;
    logic            data_wr = 1'b0;
    logic [11:0]     data_val = '0;
    logic [2:0]      we_mask = 3'd7;
    logic            ram_sel = 1'b0;
    logic [1:0]      lut_mode = 2'd0;
    logic [1:0]      curve_sel = 2'd0;
    logic            in_valid = 1'b0;
    logic [IN_W-1:0] in_r = '0, in_g = '0, in_b = '0;
    logic            out_valid;
    logic [11:0]     out_r, out_g, out_b;
    logic [2:0]      status;

    int    total = 0, fails = 0, cycles = 0;
    int    ma [2][3][256];
    int    m_idx = 0, m_ph = 0;
    bit    exp_valid = 0;
    int    exp_c [3];
    int    exp_st = 0;
    string tag = "R1", exp_tag = "R1";

    always #10 clk = ~clk;

    in_gamma_lut #(.IN_W(IN_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .idx_val(idx_val),
        .data_wr(data_wr), .data_val(data_val), .we_mask(we_mask),
        .ram_sel(ram_sel), .lut_mode(lut_mode), .curve_sel(curve_sel),
        .in_valid(in_valid), .in_r(in_r), .in_g(in_g), .in_b(in_b),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b),
        .status(status)
    );

    function automatic int st_of(int mode, int curve);
        if (mode == 2) return (curve == 1) ? 3 : (curve == 2) ? 4 : 1;
        if (mode == 3) return (curve == 1) ? 5 : (curve == 2) ? 6 : 2;
        return 0;
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        int p [3];
        p[0] = int'(in_r) >> (IN_W - 8);
        p[1] = int'(in_g) >> (IN_W - 8);
        p[2] = int'(in_b) >> (IN_W - 8);
        if (!rst_n) begin
            exp_valid = 0; exp_st = 0; m_idx = 0; m_ph = 0;
        end else begin
            exp_valid = in_valid;
            exp_tag   = tag;
            for (int c = 0; c < 3; c++)
                exp_c[c] = (lut_mode == 2) ? ma[0][c][p[c]] :
                           (lut_mode == 3) ? ma[1][c][p[c]] : p[c] * 16;
            exp_st = st_of(lut_mode, curve_sel);
            if (idx_wr) begin
                m_idx = idx_val; m_ph = 0;
            end else if (data_wr) begin
                if (we_mask[m_ph]) ma[ram_sel][m_ph][m_idx] = data_val;
                m_ph++;
                if (m_ph == 3) begin m_ph = 0; m_idx = (m_idx + 1) % 256; end
            end
        end
    end

    task automatic chk(string req, int act, int expv);
        total++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1", out_valid, 0);
            chk("R1", status, 0);
        end else begin
            chk("R6", out_valid, exp_valid);
            chk("R9", status, exp_st);
            if (exp_valid) begin
                chk(exp_tag, out_r, exp_c[0]);
                chk(exp_tag, out_g, exp_c[1]);
                chk(exp_tag, out_b, exp_c[2]);
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic set_idx(int i);
        idx_wr = 1; idx_val = 8'(i); step(); idx_wr = 0;
    endtask

    task automatic put(int v);
        data_wr = 1; data_val = 12'(v); step(); data_wr = 0;
    endtask

    task automatic pix(int r, int g, int b);
        in_valid = 1; in_r = IN_W'(r); in_g = IN_W'(g); in_b = IN_W'(b);
        step(); in_valid = 0;
    endtask

    task automatic sweep(int n);
        for (int k = 0; k < n; k++)
            pix($urandom % 1024, $urandom % 1024, $urandom % 1024);
    endtask

    initial begin
        for (int r = 0; r < 2; r++)
            for (int c = 0; c < 3; c++)
                for (int i = 0; i < 256; i++) ma[r][c][i] = 0;
        repeat (3) step();
        rst_n = 1;
        // R1: first word after reset lands in red of entry 0
        tag = "R1"; ram_sel = 0; put(12'h5A5); lut_mode = 2; step();
        pix(0, 0, 0); pix(3, 2, 1);
        // R3: full load of RAM A, then wrap into entry 0
        tag = "R3"; set_idx(0);
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++) put((i * 13 + c * 700 + 5) % 4096);
        put(12'hABC); put(12'h123); put(12'h456);
        sweep(40); pix(0, 0, 0); pix(1023, 1023, 1023);
        // R5: load RAM B while A is looked up
        tag = "R5"; ram_sel = 1; set_idx(0);
        for (int i = 0; i < 256; i++)
            for (int c = 0; c < 3; c++) begin
                put((4095 - i * 7 - c * 333 + 8192) % 4096);
                in_valid = 1; in_r = IN_W'(i * 4); in_g = IN_W'(i * 4); in_b = IN_W'(i * 4);
            end
        in_valid = 0;
        tag = "R6"; sweep(20); lut_mode = 3; curve_sel = 1; sweep(30);
        curve_sel = 2; sweep(5); curve_sel = 3; sweep(5);
        lut_mode = 2; curve_sel = 1; sweep(5); curve_sel = 2; sweep(5);
        // R7 and R8: bypass with non-zero low bits
        tag = "R7"; lut_mode = 0; pix(1023, 3, 514); sweep(10);
        tag = "R8"; lut_mode = 1; pix(7, 6, 5); sweep(10);
        lut_mode = 3; pix(1023, 1, 770);
        // R4: masked channels advance without writing
        tag = "R4"; ram_sel = 0; lut_mode = 2; set_idx(40);
        we_mask = 3'b010; put(100); put(200); put(300);
        we_mask = 3'b101; put(11); put(22); put(33);
        we_mask = 3'b000; put(1); put(2); put(3);
        we_mask = 3'b111;
        pix(160, 160, 160); pix(164, 164, 164); pix(168, 168, 168);
        // R2: index write mid-triplet restarts at red
        tag = "R2"; set_idx(90); put(777); set_idx(91); put(888); put(999); put(111);
        pix(360, 360, 360); pix(364, 364, 364);
        // R10: index write beats a data word in the same clock
        tag = "R10"; set_idx(200);
        idx_wr = 1; idx_val = 8'd201; data_wr = 1; data_val = 12'hFFF; step();
        idx_wr = 0; data_wr = 0;
        put(42); put(43); put(44);
        pix(800, 800, 800); pix(804, 804, 804);
        tag = "R6"; sweep(10);
        repeat (3) step();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            total++; fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule